// File: doc/BRIEF.md
# Protected Correlation Result Readout

This block is the processor-facing result store for one correlator channel. It holds four correlation results: in-phase and quadrature for the prompt arm and for the dither arm. On each dump pulse from the accumulators it captures all four values at once and raises a new-data status bit. It then locks the captured set so that later dumps cannot overwrite it.

The processor reads the result set through a small read port. The in-phase prompt, in-phase dither and quadrature dither results may be read in any order. The quadrature prompt result must be read last, because the falling edge of its read strobe releases the lock.

A dump that arrives while the set is locked is dropped and sets a sticky missed-data bit. That bit is cleared only by a write to the clear address, a channel reset, or the master reset. The four results and the two status words sit at consecutive addresses so that the processor can block-read them.

Top module: `acc_readout`

## Requirements
- R1: A dump with the channel enabled (`chan_rst_n` high) sets the new-data bit. This is bit 0 of the word at address 4, and it is set from the next clock edge.
- R2: While the set is locked, further dumps leave the four stored results unchanged. The four values read back therefore always come from one dump.
- R3: The lock and the new-data bit clear at the clock edge after the read strobe at address 3 falls. Reads at addresses 0, 1 and 2 do not release the lock. A read strobe held high at address 3 keeps the lock until the strobe drops.
- R4: A dump that arrives while the set is locked, and not in a release cycle, is not captured. It sets the missed-data bit, which is bit 0 of the word at address 5.
- R5: The missed-data bit stays set until a write strobe at address 6. If a new missed dump and that write fall in the same cycle, the bit stays set.
- R6: While `chan_rst_n` is low, the lock, the new-data bit and the missed-data bit are cleared and dumps are ignored. The stored results are kept.
- R7: A synchronous active-high `rst` clears the lock, both status bits, all four stored results and `rd_data`.
- R8: A dump in the same cycle as a release is captured. The set is locked again and the missed-data bit is not set.
- R9: `rd_data` is registered. It updates on the clock edge that samples `rd_en` and holds its value when `rd_en` is low. The address map is: 0 in-phase prompt, 1 in-phase dither, 2 quadrature dither, 3 quadrature prompt, 4 new-data, 5 missed-data. Unused status bits and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| chan_rst_n | input | 1 | Channel reset, active low |
| dump | input | 1 | One-cycle dump pulse from the accumulators |
| acc_ip | input | ACC_W | In-phase prompt accumulator value |
| acc_id | input | ACC_W | In-phase dither accumulator value |
| acc_qd | input | ACC_W | Quadrature dither accumulator value |
| acc_qp | input | ACC_W | Quadrature prompt accumulator value |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (a write at address 6 clears the missed-data bit) |
| addr | input | 3 | Register address |
| rd_data | output | ACC_W | Registered read data |

## Verification
The hardest situations to reach are the two that depend on exact cycle placement around the release. One is a dump landing exactly on the edge where the quadrature-prompt strobe has just dropped. The other is a dump arriving while that strobe is still held high. The stimulus reaches both by issuing the releasing read and then asserting `dump` in the very next cycle, and by holding the strobe for two cycles with a dump in the second. Coherence is then shown by reading all four values back and matching each against the dump number encoded in the value patterns.

// File: rtl/acc_readout_pkg.sv
package acc_readout_pkg;
  localparam int NUM_RES = 4;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_IP   = 3'd0,
    A_ID   = 3'd1,
    A_QD   = 3'd2,
    A_QP   = 3'd3,
    A_NEW  = 3'd4,
    A_MISS = 3'd5,
    A_CLR  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/acc_result_bank.sv
module acc_result_bank #(
  parameter int ACC_W = 16,
  parameter int NUM   = 4,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_en,
  input  logic [NUM*ACC_W-1:0] cap_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [ACC_W-1:0]     rd_val,
  output logic [NUM*ACC_W-1:0] stored
);
  logic [ACC_W-1:0] store_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)         store_q[g] <= '0;
      else if (cap_en) store_q[g] <= cap_data[g*ACC_W +: ACC_W];
    end
    assign stored[g*ACC_W +: ACC_W] = store_q[g];
  end

  assign rd_val = store_q[rd_idx];
endmodule

// File: rtl/acc_lock_ctrl.sv
module acc_lock_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic chan_en,
  input  logic dump,
  input  logic qp_rd,
  input  logic clr_wr,
  output logic locked,
  output logic missed,
  output logic capture,
  output logic release_o
);
  logic qp_rd_q;

  // Falling edge of the quadrature-prompt read strobe releases the lock.
  assign release_o = chan_en & qp_rd_q & ~qp_rd;
  assign capture   = chan_en & dump & (~locked | release_o);

  always_ff @(posedge clk) begin
    if (rst || !chan_en) qp_rd_q <= 1'b0;
    else                 qp_rd_q <= qp_rd;
  end

  always_ff @(posedge clk) begin
    if (rst || !chan_en) locked <= 1'b0;
    else if (capture)    locked <= 1'b1;
    else if (release_o)  locked <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !chan_en)                        missed <= 1'b0;
    else if (dump && locked && !release_o)      missed <= 1'b1;
    else if (clr_wr)                            missed <= 1'b0;
  end

  // R1
  new_set_chk: assert property (@(posedge clk) disable iff (rst)
    chan_en && dump |=> locked);
  // R4
  missed_set_chk: assert property (@(posedge clk) disable iff (rst)
    chan_en && dump && locked && !release_o |=> missed);
  // R5
  missed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    chan_en && missed && !clr_wr |=> missed);
  // R6
  chan_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !locked && !missed);
  // R3
  release_chk: assert property (@(posedge clk) disable iff (rst)
    release_o && !dump |=> !locked);
  // R8
  coincide_chk: assert property (@(posedge clk) disable iff (rst)
    release_o && dump && !missed |=> locked && !missed);
endmodule

// File: rtl/acc_read_port.sv
module acc_read_port
  import acc_readout_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ACC_W-1:0]  bank_val,
  input  logic              new_bit,
  input  logic              missed_bit,
  output logic [ACC_W-1:0]  rd_data
);
  logic [ACC_W-1:0] mux_val;

  always_comb begin
    mux_val = '0;
    case (addr)
      A_IP, A_ID, A_QD, A_QP: mux_val = bank_val;
      A_NEW:                  mux_val[0] = new_bit;
      A_MISS:                 mux_val[0] = missed_bit;
      default:                mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mux_val;
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/acc_readout.sv
module acc_readout
  import acc_readout_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_rst_n,
  input  logic              dump,
  input  logic [ACC_W-1:0]  acc_ip,
  input  logic [ACC_W-1:0]  acc_id,
  input  logic [ACC_W-1:0]  acc_qd,
  input  logic [ACC_W-1:0]  acc_qp,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [ACC_W-1:0]  rd_data
);
  localparam int IDX_W = $clog2(NUM_RES);

  logic                     locked, missed, capture, rel;
  logic [NUM_RES*ACC_W-1:0] cap_data, stored;
  logic [ACC_W-1:0]         bank_val;
  logic                     qp_rd, clr_wr;

  assign cap_data = {acc_qp, acc_qd, acc_id, acc_ip};
  assign qp_rd    = rd_en && (addr == A_QP);
  assign clr_wr   = wr_en && (addr == A_CLR);

  acc_lock_ctrl u_ctrl (
    .clk(clk), .rst(rst), .chan_en(chan_rst_n), .dump(dump),
    .qp_rd(qp_rd), .clr_wr(clr_wr), .locked(locked), .missed(missed),
    .capture(capture), .release_o(rel)
  );

  acc_result_bank #(.ACC_W(ACC_W), .NUM(NUM_RES)) u_bank (
    .clk(clk), .rst(rst), .cap_en(capture), .cap_data(cap_data),
    .rd_idx(addr[IDX_W-1:0]), .rd_val(bank_val), .stored(stored)
  );

  acc_read_port #(.ACC_W(ACC_W)) u_rport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .bank_val(bank_val),
    .new_bit(locked), .missed_bit(missed), .rd_data(rd_data)
  );

  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked && !rel |=> $stable(stored));
endmodule

// File: tb/acc_readout_bench.sv
module acc_readout_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_rst_n = 1'b1;
  logic dump = 1'b0;
  logic [W-1:0] acc_ip = '0, acc_id = '0, acc_qd = '0, acc_qp = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [W-1:0] rd_data;

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_readout #(.ACC_W(W)) u_acc_readout (
    .clk(clk), .rst(rst), .chan_rst_n(chan_rst_n), .dump(dump),
    .acc_ip(acc_ip), .acc_id(acc_id), .acc_qd(acc_qd), .acc_qp(acc_qp),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rd_data(rd_data)
  );

  function automatic int val(int k, int i);
    return k * 16 + i + 1;
  endfunction

  // Monitor: compare each completed read against the scoreboard.
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expected item, actual %0d", rd_data);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (int'(rd_data) != e) begin
          fails++;
          $display("FAIL %s: actual %0d expected %0d", t, rd_data, e);
        end
      end
    end
  end

  task automatic set_acc(int k);
    acc_ip = W'(val(k, 0)); acc_id = W'(val(k, 1));
    acc_qd = W'(val(k, 2)); acc_qp = W'(val(k, 3));
  endtask

  task automatic do_dump(int k);
    set_acc(k); dump = 1'b1;
    @(negedge clk); dump = 1'b0;
  endtask

  task automatic do_read(int a, int e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = 3'(a); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_clear();
    addr = 3'd6; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    for (int a = 0; a < 6; a++) do_read(a, 0, "R7 reset state");
    // R1, R2, R4: capture, locked set, overrun
    do_dump(1);
    do_read(4, 1, "R1 new bit after dump");
    do_read(0, val(1, 0), "R2 ip");
    do_read(1, val(1, 1), "R3 id read keeps lock");
    do_read(2, val(1, 2), "R2 qd");
    do_dump(2);
    do_read(5, 1, "R4 missed on locked dump");
    do_read(3, val(1, 3), "R2 qp coherent with first dump");
    idle(1);
    do_read(4, 0, "R3 new bit cleared by release");
    do_read(5, 1, "R5 missed sticky");
    // R3 any order
    do_dump(3);
    do_read(2, val(3, 2), "R3 order qd");
    do_read(0, val(3, 0), "R3 order ip");
    do_read(1, val(3, 1), "R3 order id");
    do_read(3, val(3, 3), "R3 order qp");
    idle(1);
    do_clear();
    do_read(5, 0, "R5 cleared by write");
    // R8 dump in release cycle
    do_dump(4);
    do_read(3, val(4, 3), "R8 qp of dump 4");
    do_dump(5);
    do_read(5, 0, "R8 no missed on coincident dump");
    do_read(4, 1, "R8 relocked");
    do_read(0, val(5, 0), "R8 ip of dump 5");
    do_read(3, val(5, 3), "R8 qp of dump 5");
    idle(1);
    // R5 set wins over clear
    do_dump(6);
    set_acc(7); dump = 1'b1; addr = 3'd6; wr_en = 1'b1;
    @(negedge clk); dump = 1'b0; wr_en = 1'b0;
    do_read(5, 1, "R5 set wins over clear");
    do_clear();
    do_read(5, 0, "R5 clear write");
    // R6 channel reset
    do_dump(7);
    chan_rst_n = 1'b0; set_acc(8); dump = 1'b1;
    @(negedge clk); dump = 1'b0; chan_rst_n = 1'b1;
    do_read(4, 0, "R6 new cleared by channel reset");
    do_read(5, 0, "R6 missed cleared by channel reset");
    do_read(0, val(6, 0), "R6 values kept, dump ignored");
    do_dump(9);
    do_read(1, val(9, 1), "R6 capture after channel reset");
    do_read(3, val(9, 3), "R6 qp");
    idle(1);
    // R3 held qp strobe keeps lock
    do_dump(10);
    exp_q.push_back(val(10, 3)); tag_q.push_back("R3 held qp 1");
    exp_q.push_back(val(10, 3)); tag_q.push_back("R3 held qp 2");
    addr = 3'd3; rd_en = 1'b1;
    @(negedge clk); set_acc(11); dump = 1'b1;
    @(negedge clk); dump = 1'b0; rd_en = 1'b0;
    do_read(5, 1, "R3 dump during held strobe missed");
    idle(1);
    do_read(4, 0, "R3 released after strobe drop");
    do_read(0, val(10, 0), "R2 dump 11 not captured");
    do_clear();
    do_read(7, 0, "R9 unmapped reads zero");
    // R7 master reset mid-run
    do_dump(12);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    for (int a = 0; a < 6; a++) do_read(a, 0, "R7 master reset clears");
    idle(2);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d reads not seen, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule